// File: doc/BRIEF.md
# I2C Slave Write Receiver with Word Assembly

This block is a slave on a two-wire serial bus. It receives only. It oversamples the clock line and the data line on its own system clock and waits for a START condition. It then shifts in the address byte, with the most significant bit first. The seven address bits are compared against the block's own address. The upper five bits of that address come from a parameter and the lower two come from strap pins. When the address matches and the direction bit asks for a write, the block acknowledges. Each data byte that follows is then acknowledged on its own.

The bytes are grouped into words of one, two or three bytes. A word enters a small receive FIFO only after its last byte has arrived. The address byte never counts toward a word. The word size is read from a select input at the moment the address is acknowledged. A STOP or a repeated START closes the session. If it closes with part of a word collected, that part is thrown away and a sticky error flag is raised. Driving the enable low empties the FIFO, clears both flags and sends the controller back to idle. While enable is low, the block ignores bus traffic.

Top module: `i2c_slave_word_rx`

## Requirements
- R1: After reset, and again after enable is driven low, sda_oe is 0, fifo_empty is 1, fifo_full is 0, and rx_err and rx_ovf are both 0.
- R2: A START is SDA falling while SCL is high. The byte after a START is shifted in MSB first, and its upper seven bits are compared with {ADDR_HI, addr_strap[1:0]}.
- R3: When the address matches and bit 0 of the address byte (the direction bit) is 0, sda_oe is 1 while SCL is high in the ninth clock of the address byte.
- R4: When the address does not match, or the direction bit is 1, sda_oe stays 0 on the ninth clock. It then stays 0 for every later byte until the next START, and nothing is written into the FIFO.
- R5: In a write session, sda_oe is 1 while SCL is high in the ninth clock of every data byte, and is released after that clock's falling edge.
- R6: The word size comes from word_sel as taken at the address acknowledge: 00 means 1 byte, 01 means 2 bytes, 10 and 11 mean 3 bytes. A change to word_sel during the session has no effect on that session.
- R7: A word is written into the FIFO once the configured number of data bytes has arrived. It is right-aligned in rd_data. The first byte sits in the most significant byte of the word, and unused upper bits are 0. The address byte is not counted.
- R8: If a STOP (SDA rising while SCL is high) or a repeated START arrives after at least one complete byte of an unfinished word, that partial word is discarded and rx_err is set. rx_err stays set until enable is driven low.
- R9: A completed word that arrives while the FIFO holds FIFO_DEPTH words is dropped and rx_ovf is set. The words already stored are left unchanged.
- R10: While enable is 0, the FIFO is emptied, the flags are cleared and no byte is acknowledged.
- R11: rd_data shows the oldest stored word whenever fifo_empty is 0. A cycle with rd_en high removes that word, so words come out in arrival order.
- R12: A repeated START that follows a complete word starts a new address phase with no error, and a matching write session after it stores words normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; low clears the FIFO and the flags and idles the controller |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| addr_strap | input | 2 | Lower two bits of the slave address |
| word_sel | input | 2 | Bytes per word: 00=1, 01=2, 10/11=3 |
| sda_oe | output | 1 | Pull SDA low when 1 (open-drain enable) |
| rd_en | input | 1 | Pop the oldest FIFO word |
| rd_data | output | 24 | Oldest FIFO word, right-aligned |
| fifo_empty | output | 1 | FIFO holds no word |
| fifo_full | output | 1 | FIFO holds FIFO_DEPTH words |
| rx_err | output | 1 | Sticky: a partial word was discarded |
| rx_ovf | output | 1 | Sticky: a word was dropped because the FIFO was full |

## Verification
A wrong bit count or a wrong state shows up within one byte time on sda_oe. The acknowledge pulse either goes missing or lands one SCL clock early or late, so the bus master sees it on that very byte. A fault in the byte counter or in the packing shift shows up only at the first word boundary. At that point the FIFO gains a word too early or too late, or rd_data carries its bytes in the wrong order. A fault in the discard logic stays hidden until the session ends. It then appears as an rx_err value that does not fit the number of bytes sent, or as a stray word left in the FIFO.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int BYTE_W    = 8;
  localparam int MAX_BYTES = 3;
  localparam int WORD_W    = BYTE_W * MAX_BYTES;
  localparam int ADDR_W    = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_SKIP
  } rx_state_t;

  // bytes per word from the select code; 11 is treated as 3
  function automatic logic [1:0] bytes_per_word(input logic [1:0] sel);
    case (sel)
      2'b00:   return 2'd1;
      2'b01:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  // shift a new byte into the low end of the word under assembly
  function automatic logic [WORD_W-1:0] pack_byte(input logic [WORD_W-1:0] acc,
                                                  input logic [BYTE_W-1:0] b);
    return {acc[WORD_W-BYTE_W-1:0], b};
  endfunction

  function automatic logic [ADDR_W-1:0] own_addr(input logic [ADDR_W-3:0] hi,
                                                 input logic [1:0] strap);
    return {hi, strap};
  endfunction
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] lvl,
  output logic [W-1:0] prv,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] stg [STAGES+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= d;
      for (int i = 1; i <= STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign lvl  = stg[STAGES-1];
  assign prv  = stg[STAGES];
  assign rise = lvl & ~prv;
  assign fall = ~lvl & prv;
endmodule

// File: rtl/i2cw_fifo.sv
module i2cw_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       wr,
  input  logic [W-1:0]               wdata,
  input  logic                       rd,
  output logic [W-1:0]               rdata,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_wr, do_rd;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign do_rd = rd && !empty && !clr;
  assign do_wr = wr && (!full || do_rd) && !clr;
  assign drop  = wr && full && !do_rd && !clr;
  assign rdata = mem[rp];
  assign level = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) begin
        mem[wp] <= wdata;
        wp      <= nxt(wp);
      end
      if (do_rd) rp <= nxt(rp);
      if (do_wr && !do_rd) cnt <= cnt + CW'(1);
      else if (do_rd && !do_wr) cnt <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/i2c_slave_word_rx.sv
module i2c_slave_word_rx
  import i2cw_pkg::*;
#(
  parameter logic [4:0] ADDR_HI     = 5'b10100,
  parameter int         FIFO_DEPTH  = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        addr_strap,
  input  logic [1:0]        word_sel,
  output logic              sda_oe,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              fifo_empty,
  output logic              fifo_full,
  output logic              rx_err,
  output logic              rx_ovf
);
  localparam int LVL_W = $clog2(FIFO_DEPTH+1);

  // synchronized bus lines: bit 1 = SCL, bit 0 = SDA
  logic [1:0] bus_lvl, bus_prv, bus_rise, bus_fall;

  i2cw_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({scl_i, sda_i}),
    .lvl  (bus_lvl),
    .prv  (bus_prv),
    .rise (bus_rise),
    .fall (bus_fall)
  );

  logic scl_hi, scl_rise, scl_fall, sda_now;
  logic start_ev, stop_ev;
  assign scl_hi   = bus_lvl[1] & bus_prv[1];
  assign scl_rise = bus_rise[1];
  assign scl_fall = bus_fall[1];
  assign sda_now  = bus_lvl[0];
  assign start_ev = scl_hi & bus_fall[0];
  assign stop_ev  = scl_hi & bus_rise[0];

  rx_state_t         st;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [WORD_W-1:0] acc;
  logic [1:0]        byte_cnt;
  logic [1:0]        nbytes;
  logic              byte_done;
  logic              word_push;
  logic [WORD_W-1:0] push_word;
  logic              fifo_drop;
  logic [LVL_W-1:0]  fifo_level;

  // named events for the checker
  logic ack_phase, skip_phase, in_data, addr_hit, partial_word;
  logic [WORD_W-1:0] acc_next;
  assign ack_phase    = (st == ST_ADDR_ACK) || (st == ST_DATA_ACK);
  assign skip_phase   = (st == ST_SKIP);
  assign in_data      = (st == ST_DATA) || (st == ST_DATA_ACK);
  assign addr_hit     = (shreg[BYTE_W-1:1] == own_addr(ADDR_HI, addr_strap)) && !shreg[0];
  assign partial_word = in_data && (byte_cnt != 2'd0);
  assign acc_next     = pack_byte(acc, shreg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      acc       <= '0;
      byte_cnt  <= '0;
      nbytes    <= 2'd1;
      sda_oe    <= 1'b0;
      rx_err    <= 1'b0;
      rx_ovf    <= 1'b0;
      byte_done <= 1'b0;
      word_push <= 1'b0;
      push_word <= '0;
    end else if (!en) begin
      st        <= ST_IDLE;
      bit_cnt   <= '0;
      acc       <= '0;
      byte_cnt  <= '0;
      sda_oe    <= 1'b0;
      rx_err    <= 1'b0;
      rx_ovf    <= 1'b0;
      byte_done <= 1'b0;
      word_push <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      word_push <= 1'b0;
      if (fifo_drop) rx_ovf <= 1'b1;
      if (start_ev) begin
        if (partial_word) rx_err <= 1'b1;
        st       <= ST_ADDR;
        bit_cnt  <= '0;
        acc      <= '0;
        byte_cnt <= '0;
        sda_oe   <= 1'b0;
      end else if (stop_ev) begin
        if (partial_word) rx_err <= 1'b1;
        st       <= ST_IDLE;
        acc      <= '0;
        byte_cnt <= '0;
        sda_oe   <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_DATA: begin
            if (scl_rise && bit_cnt < 4'd8) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_now};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              if (st == ST_ADDR) begin
                if (addr_hit) begin
                  sda_oe <= 1'b1;
                  nbytes <= bytes_per_word(word_sel);
                  st     <= ST_ADDR_ACK;
                end else begin
                  st <= ST_SKIP;
                end
              end else begin
                sda_oe    <= 1'b1;
                byte_done <= 1'b1;
                st        <= ST_DATA_ACK;
                if (byte_cnt + 2'd1 == nbytes) begin
                  word_push <= 1'b1;
                  push_word <= acc_next;
                  acc       <= '0;
                  byte_cnt  <= '0;
                end else begin
                  acc      <= acc_next;
                  byte_cnt <= byte_cnt + 2'd1;
                end
              end
            end
          end
          ST_ADDR_ACK, ST_DATA_ACK: begin
            if (scl_fall) begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              st      <= ST_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  i2cw_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (!en),
    .wr   (word_push),
    .wdata(push_word),
    .rd   (rd_en),
    .rdata(rd_data),
    .empty(fifo_empty),
    .full (fifo_full),
    .level(fifo_level),
    .drop (fifo_drop)
  );
endmodule

// File: rtl/i2cw_checker.sv
module i2cw_checker #(
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       en,
  input logic                       sda_oe,
  input logic                       fifo_empty,
  input logic                       fifo_full,
  input logic                       rx_err,
  input logic                       rx_ovf,
  input logic                       byte_done,
  input logic                       word_push,
  input logic                       ack_phase,
  input logic                       skip_phase,
  input logic [$clog2(DEPTH+1)-1:0] fifo_level
);
  p_ack_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> ack_phase);

  p_skip_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    skip_phase |-> !sda_oe);

  p_push_on_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    word_push |-> byte_done);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rx_err) |=> rx_err);

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rx_ovf) |=> rx_ovf);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= ($clog2(DEPTH+1))'(DEPTH));

  p_disable_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (fifo_empty && !sda_oe && !rx_err && !rx_ovf));

  p_empty_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_empty && fifo_full));
endmodule

bind i2c_slave_word_rx i2cw_checker #(.DEPTH(FIFO_DEPTH)) u_i2cw_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .sda_oe    (sda_oe),
  .fifo_empty(fifo_empty),
  .fifo_full (fifo_full),
  .rx_err    (rx_err),
  .rx_ovf    (rx_ovf),
  .byte_done (byte_done),
  .word_push (word_push),
  .ack_phase (ack_phase),
  .skip_phase(skip_phase),
  .fifo_level(fifo_level)
);

// File: tb/test_i2c_slave_word_rx.sv
module test_i2c_slave_word_rx;
  localparam int Q = 10;           // system clocks per quarter SCL period
  localparam logic [6:0] MY_ADDR = 7'b1010011;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        m_scl = 1'b1;
  logic        m_sda = 1'b1;
  logic [1:0]  addr_strap = 2'b11;
  logic [1:0]  word_sel = 2'b00;
  logic        rd_en = 1'b0;
  logic        sda_oe;
  logic [23:0] rd_data;
  logic        fifo_empty, fifo_full, rx_err, rx_ovf;
  logic        sda_line;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;            // 250 MHz
  assign sda_line = m_sda & ~sda_oe;

  i2c_slave_word_rx i_i2c_slave_word_rx (
    .clk(clk), .rst_n(rst_n), .en(en), .scl_i(m_scl), .sda_i(sda_line),
    .addr_strap(addr_strap), .word_sel(word_sel), .sda_oe(sda_oe),
    .rd_en(rd_en), .rd_data(rd_data), .fifo_empty(fifo_empty),
    .fifo_full(fifo_full), .rx_err(rx_err), .rx_ovf(rx_ovf)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_q(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic do_start();
    wait_q(1); m_sda = 1'b1;
    wait_q(1); m_scl = 1'b1;
    wait_q(1); m_sda = 1'b0;
    wait_q(1); m_scl = 1'b0;
  endtask

  task automatic do_stop();
    wait_q(1); m_sda = 1'b0;
    wait_q(1); m_scl = 1'b1;
    wait_q(1); m_sda = 1'b1;
    wait_q(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      wait_q(1); m_sda = b[i];
      wait_q(1); m_scl = 1'b1;
      wait_q(2); m_scl = 1'b0;
    end
    wait_q(1); m_sda = 1'b1;
    wait_q(1); m_scl = 1'b1;
    wait_q(1); acked = (sda_line == 1'b0);
    wait_q(1); m_scl = 1'b0;
  endtask

  task automatic pop_expect(input string req, input logic [23:0] exp);
    check({req, " not empty"}, 32'(fifo_empty), 32'd0);
    check({req, " word"}, 32'(rd_data), 32'(exp));
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear_block();
    en = 1'b0;
    repeat (4) @(negedge clk);
    en = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // write session: START, address, n data bytes; every ack checked
  task automatic write_bytes(input logic [7:0] bq [6], input int n, input string req);
    logic a;
    send_byte({MY_ADDR, 1'b0}, a);
    check({req, " R3 addr ack"}, 32'(a), 32'd1);
    for (int k = 0; k < n; k++) begin
      send_byte(bq[k], a);
      check({req, " R5 data ack"}, 32'(a), 32'd1);
    end
  endtask

  function automatic logic [23:0] ref_word(input logic [7:0] bq [6], input int first, input int n);
    logic [23:0] w = '0;
    for (int k = 0; k < n; k++) w = w * 24'd256 + 24'(bq[first + k]);
    return w;
  endfunction

  task automatic t_reset();
    check("R1 sda_oe", 32'(sda_oe), 32'd0);
    check("R1 empty", 32'(fifo_empty), 32'd1);
    check("R1 full", 32'(fifo_full), 32'd0);
    check("R1 flags", {30'd0, rx_err, rx_ovf}, 32'd0);
  endtask

  task automatic t_one_byte_words();
    logic [7:0] bq [6] = '{8'hA5, 8'h3C, 8'h81, 8'h00, 8'h00, 8'h00};
    clear_block();
    word_sel = 2'b00;
    do_start();
    write_bytes(bq, 3, "R2");
    do_stop();
    for (int k = 0; k < 3; k++) pop_expect("R7 R11 1-byte", ref_word(bq, k, 1));
    check("R11 drained", 32'(fifo_empty), 32'd1);
    check("R8 no err", 32'(rx_err), 32'd0);
  endtask

  task automatic t_two_byte_words();
    logic [7:0] bq [6] = '{8'h12, 8'h34, 8'hCA, 8'hFE, 8'h00, 8'h00};
    clear_block();
    word_sel = 2'b01;
    do_start();
    write_bytes(bq, 4, "R6");
    do_stop();
    pop_expect("R6 R7 2-byte w0", ref_word(bq, 0, 2));
    pop_expect("R6 R7 2-byte w1", ref_word(bq, 2, 2));
    check("R7 addr not counted", 32'(fifo_empty), 32'd1);
  endtask

  task automatic t_three_byte_words();
    logic [7:0] bq [6] = '{8'hDE, 8'hAD, 8'hBE, 8'h01, 8'h02, 8'h03};
    clear_block();
    word_sel = 2'b10;
    do_start();
    write_bytes(bq, 3, "R6 sel10");
    do_stop();
    pop_expect("R6 3-byte sel10", ref_word(bq, 0, 3));
    word_sel = 2'b11;
    do_start();
    begin
      logic a;
      send_byte({MY_ADDR, 1'b0}, a);
      check("R3 addr ack sel11", 32'(a), 32'd1);
      word_sel = 2'b00;                       // ignored mid-session (R6)
      for (int k = 3; k < 6; k++) begin
        send_byte(bq[k], a);
        check("R5 data ack sel11", 32'(a), 32'd1);
      end
    end
    do_stop();
    pop_expect("R6 3-byte sel11 latched", ref_word(bq, 3, 3));
    check("R6 single word", 32'(fifo_empty), 32'd1);
  endtask

  task automatic t_no_match();
    logic a;
    clear_block();
    word_sel = 2'b00;
    do_start();
    send_byte({MY_ADDR ^ 7'b0000001, 1'b0}, a);
    check("R4 wrong addr nack", 32'(a), 32'd0);
    send_byte(8'h55, a);
    check("R4 skip data nack", 32'(a), 32'd0);
    do_stop();
    do_start();
    send_byte({MY_ADDR, 1'b1}, a);
    check("R4 read nack", 32'(a), 32'd0);
    send_byte(8'h66, a);
    check("R4 read skip nack", 32'(a), 32'd0);
    do_stop();
    check("R4 fifo empty", 32'(fifo_empty), 32'd1);
  endtask

  task automatic t_partial_stop();
    logic [7:0] bq [6] = '{8'h11, 8'h22, 8'h33, 8'h00, 8'h00, 8'h00};
    clear_block();
    word_sel = 2'b01;
    do_start();
    write_bytes(bq, 3, "R8");
    do_stop();
    check("R8 err on stop", 32'(rx_err), 32'd1);
    pop_expect("R8 full word kept", ref_word(bq, 0, 2));
    check("R8 partial dropped", 32'(fifo_empty), 32'd1);
  endtask

  task automatic t_restart();
    logic [7:0] bq [6] = '{8'h70, 8'h71, 8'h72, 8'h73, 8'h00, 8'h00};
    logic [7:0] b2 [6] = '{8'h72, 8'h73, 8'h00, 8'h00, 8'h00, 8'h00};
    logic [7:0] b1 [6] = '{8'h71, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    clear_block();
    word_sel = 2'b00;
    do_start();
    write_bytes(bq, 1, "R12 first");
    do_start();
    write_bytes(b1, 1, "R12 second");
    do_stop();
    check("R12 no err", 32'(rx_err), 32'd0);
    pop_expect("R12 w0", 24'h70);
    pop_expect("R12 w1", 24'h71);
    word_sel = 2'b01;
    do_start();
    write_bytes(bq, 1, "R8 restart");
    do_start();
    check("R8 err on restart", 32'(rx_err), 32'd1);
    write_bytes(b2, 2, "R8 after restart");
    do_stop();
    pop_expect("R8 word after restart", ref_word(b2, 0, 2));
    check("R8 restart partial dropped", 32'(fifo_empty), 32'd1);
  endtask

  task automatic t_overflow();
    logic [7:0] bq [6] = '{8'hC0, 8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'h00};
    clear_block();
    word_sel = 2'b00;
    do_start();
    write_bytes(bq, 5, "R9");
    do_stop();
    check("R9 full", 32'(fifo_full), 32'd1);
    check("R9 ovf", 32'(rx_ovf), 32'd1);
    for (int k = 0; k < 4; k++) pop_expect("R9 R11 kept", ref_word(bq, k, 1));
    check("R9 fifth dropped", 32'(fifo_empty), 32'd1);
  endtask

  task automatic t_disable();
    logic [7:0] bq [6] = '{8'h9A, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    logic a;
    clear_block();
    word_sel = 2'b01;
    do_start();
    write_bytes(bq, 1, "R10");
    do_stop();
    check("R10 err before", 32'(rx_err), 32'd1);
    do_start();
    write_bytes(bq, 1, "R10 b");          // stored? no: sel=01, partial again
    do_stop();
    en = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 flags cleared", {30'd0, rx_err, rx_ovf}, 32'd0);
    check("R10 empty", 32'(fifo_empty), 32'd1);
    do_start();
    send_byte({MY_ADDR, 1'b0}, a);
    check("R10 no ack disabled", 32'(a), 32'd0);
    do_stop();
    en = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_one_byte_words();
    t_two_byte_words();
    t_three_byte_words();
    t_no_match();
    t_partial_stop();
    t_restart();
    t_overflow();
    t_disable();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule